// File: doc/BRIEF.md
# Compare-Match Timer with PWM Output

This block is an up-counting timer with two compare registers, called P and A, and a complementary pair of output pins. The counter clock comes from one of several sources, chosen by a 3-bit field. Four of them are power-of-four ratios of the system clock. Two are tick-enable strobes, one from an internal high-speed clock and one from a low-speed sub clock. The last is an external pin, synchronised inside the block, that counts events on its rising or falling edge.

Each comparator raises its own sticky interrupt flag when the counter equals its compare value on an active tick. In compare-output mode, one selectable comparator restarts the counter, and a match on comparator A sets, clears or toggles the output pin. In PWM mode, comparator P fixes the period and comparator A the duty cycle.

Software programs the block through a small write port with four addresses:

| Address | Content |
|---|---|
| 0 | Control word |
| 1 | P compare value |
| 2 | A compare value |
| 3 | Flag clear, write 1 to clear; bit 0 clears the P flag, bit 1 clears the A flag |

The control word at address 0 packs these fields:

| Bits | Field | Meaning |
|---|---|---|
| 0 | run | Enables counting |
| 3:1 | clock select | Counter clock source |
| 4 | mode | 1 selects PWM |
| 6:5 | match action | Output action on an A match |
| 7 | clear source | 1 makes A the clear source, 0 makes P the clear source |
| 8 | edge | 1 selects the falling edge of the external pin |
| 9 | idle | Idle level of the output |

Top module: `match_pwm_timer`

## Requirements
- R1: After reset, count_o is 0, both flags are 0, wave_o is 0 and wave_n_o is 1.
- R2: The clock-select field picks the counting source. Codes 0, 1, 2 and 3 advance the counter once every 1, 4, 16 and 64 system cycles, with the prescaler restarting when run goes high. Code 4 counts cycles with hi_tick high. Code 5 counts cycles with sub_tick high. Code 7 never counts, and a non-selected source has no effect on count_o.
- R3: Code 6 counts edges of ext_clk after a two-flop synchroniser. Each rising edge (edge bit 0) or each falling edge (edge bit 1) adds exactly one.
- R4: A flag sets on an active tick while count_o equals that comparator's value. It then stays set until a 1 is written to its bit at address 3 (bit 0 for P, bit 1 for A). If a set and a clear arrive in the same cycle, the flag ends up set.
- R5: In compare mode, the comparator named by the clear-source bit (0 = P, 1 = A) returns the counter to 0 on its matching tick instead of incrementing. A match on the other comparator only sets its flag.
- R6: In compare mode, a tick on which the counter equals A applies the match action to wave_o: 0 holds, 1 drives low, 2 drives high, 3 toggles.
- R7: In PWM mode, a P match restarts the counter at 0 whatever the clear-source bit says, and wave_o is 1 exactly while count_o is below A.
- R8: wave_n_o is always the inverse of wave_o.
- R9: While run is 0, count_o holds its value, wave_o equals the idle bit, and the compare-mode output is reloaded with the idle bit.
- R10: Without a clearing match, the counter wraps from 2^CNT_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DATA_W | Write data |
| hi_tick | input | 1 | Internal high-clock tick enable |
| sub_tick | input | 1 | Sub-clock tick enable |
| ext_clk | input | 1 | External clock or event pin, asynchronous |
| wave_o | output | 1 | Primary timer output |
| wave_n_o | output | 1 | Complementary timer output |
| flag_p_o | output | 1 | Sticky P match flag |
| flag_a_o | output | 1 | Sticky A match flag |
| count_o | output | CNT_W | Current counter value |

## Verification
The properties assume that hi_tick and sub_tick are synchronous single-cycle strobes. They also assume that each level of ext_clk lasts at least one clock, so that the synchroniser sees every edge, and that compare values change only while run is 0. The stimulus drives the tick strobes at falling clock edges and holds each ext_clk level for three cycles. It stops toggling the pin several cycles before run is cleared, and writes compare values only with the timer stopped. Flag-clear writes land at random cycles during a run, and a directed case makes one coincide with a match.

// File: rtl/mpt_pkg.sv
`timescale 1ns/1ps
package mpt_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    ADR_CTL  = 2'd0,
    ADR_CMPP = 2'd1,
    ADR_CMPA = 2'd2,
    ADR_FLAG = 2'd3
  } addr_e;

  // control word, bit 0 = run at the LSB
  typedef struct packed {
    logic       idle;
    logic       ext_fall;
    logic       clr_on_a;
    act_e       act;
    logic       pwm;
    logic [2:0] sel;
    logic       run;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/mpt_tick_gen.sv
`timescale 1ns/1ps
module mpt_tick_gen #(
  parameter int NUM_RATIOS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  input  logic       ext_fall,
  input  logic       hi_tick,
  input  logic       sub_tick,
  input  logic       ext_pin,
  output logic       tick
);
  localparam int PSC_W  = (NUM_RATIOS > 1) ? 2 * (NUM_RATIOS - 1) : 1;
  localparam int SEL_HI  = NUM_RATIOS;
  localparam int SEL_SUB = NUM_RATIOS + 1;
  localparam int SEL_EXT = NUM_RATIOS + 2;

  logic [PSC_W-1:0]       psc_q, psc_d;
  logic [NUM_RATIOS-1:0]  ratio_hit;
  logic [SYNC_STAGES:0]   sync_q, sync_d;
  logic                   ext_edge;
  logic                   src;

  always_comb psc_d = run ? psc_q + 1'b1 : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

  for (genvar k = 0; k < NUM_RATIOS; k++) begin : g_ratio
    if (k == 0) begin : g_div1
      assign ratio_hit[k] = 1'b1;
    end else begin : g_divn
      assign ratio_hit[k] = &psc_q[2*k-1:0];
    end
  end

  // synchroniser plus one history stage for edge detection
  always_comb sync_d = {sync_q[SYNC_STAGES-1:0], ext_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  always_comb begin
    if (ext_fall) ext_edge = !sync_q[SYNC_STAGES-1] &&  sync_q[SYNC_STAGES];
    else          ext_edge =  sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];
  end

  always_comb begin
    src = 1'b0;
    for (int k = 0; k < NUM_RATIOS; k++) begin
      if (sel == 3'(k)) src = ratio_hit[k];
    end
    if (sel == 3'(SEL_HI))  src = hi_tick;
    if (sel == 3'(SEL_SUB)) src = sub_tick;
    if (sel == 3'(SEL_EXT)) src = ext_edge;
  end

  assign tick = run && src;

endmodule

// File: rtl/mpt_core.sv
`timescale 1ns/1ps
module mpt_core #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pwm,
  input  logic             clr_on_a,
  input  logic [CNT_W-1:0] cmp_p,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [1:0]       flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_a,
  output logic [1:0]       flags
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       flags_q, flags_d;
  logic             hit_p, restart;

  always_comb begin
    hit_p   = tick && (cnt_q == cmp_p);
    hit_a   = tick && (cnt_q == cmp_a);
    restart = pwm ? hit_p : (clr_on_a ? hit_a : hit_p);
    if (!tick)        cnt_d = cnt_q;
    else if (restart) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
    flags_d = (flags_q & ~flag_clr) | {hit_a, hit_p};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flags_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      flags_q <= flags_d;
    end
  end

  assign cnt   = cnt_q;
  assign flags = flags_q;

endmodule

// File: rtl/mpt_out.sv
`timescale 1ns/1ps
module mpt_out
  import mpt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pwm,
  input  logic             idle,
  input  act_e             act,
  input  logic             hit_a,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_a,
  output logic             wave,
  output logic             wave_n
);
  logic cmp_q, cmp_d;

  always_comb begin
    cmp_d = cmp_q;
    if (!run) begin
      cmp_d = idle;
    end else if (!pwm && hit_a) begin
      case (act)
        ACT_LOW:    cmp_d = 1'b0;
        ACT_HIGH:   cmp_d = 1'b1;
        ACT_TOGGLE: cmp_d = !cmp_q;
        default:    cmp_d = cmp_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= 1'b0;
    else        cmp_q <= cmp_d;
  end

  always_comb begin
    if (!run)     wave = idle;
    else if (pwm) wave = (cnt < cmp_a);
    else          wave = cmp_q;
  end

  assign wave_n = !wave;

endmodule

// File: rtl/match_pwm_timer.sv
`timescale 1ns/1ps
module match_pwm_timer
  import mpt_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int DATA_W     = 16,
  parameter int NUM_RATIOS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hi_tick,
  input  logic              sub_tick,
  input  logic              ext_clk,
  output logic              wave_o,
  output logic              wave_n_o,
  output logic              flag_p_o,
  output logic              flag_a_o,
  output logic [CNT_W-1:0]  count_o
);
  logic             rst_meta, rst_s_n;
  ctl_t             ctl_q, ctl_d;
  logic [CNT_W-1:0] cmpp_q, cmpp_d, cmpa_q, cmpa_d;
  logic [1:0]       flag_clr;
  logic             tick, hit_a;
  logic [1:0]       flags;
  logic             unused_bits;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  always_comb begin
    ctl_d    = ctl_q;
    cmpp_d   = cmpp_q;
    cmpa_d   = cmpa_q;
    flag_clr = 2'b00;
    if (wr_en) begin
      case (addr_e'(wr_addr))
        ADR_CTL:  ctl_d    = ctl_t'(wr_data[CTL_W-1:0]);
        ADR_CMPP: cmpp_d   = wr_data[CNT_W-1:0];
        ADR_CMPA: cmpa_d   = wr_data[CNT_W-1:0];
        default:  flag_clr = wr_data[1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctl_q  <= '0;
      cmpp_q <= '0;
      cmpa_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      cmpp_q <= cmpp_d;
      cmpa_q <= cmpa_d;
    end
  end

  assign unused_bits = ^wr_data;

  mpt_tick_gen #(.NUM_RATIOS(NUM_RATIOS), .SYNC_STAGES(2)) u_tick (
    .clk(clk), .rst_n(rst_s_n), .run(ctl_q.run), .sel(ctl_q.sel),
    .ext_fall(ctl_q.ext_fall), .hi_tick(hi_tick), .sub_tick(sub_tick),
    .ext_pin(ext_clk), .tick(tick)
  );

  mpt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_s_n), .tick(tick), .pwm(ctl_q.pwm),
    .clr_on_a(ctl_q.clr_on_a), .cmp_p(cmpp_q), .cmp_a(cmpa_q),
    .flag_clr(flag_clr), .cnt(count_o), .hit_a(hit_a), .flags(flags)
  );

  mpt_out #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_s_n), .run(ctl_q.run), .pwm(ctl_q.pwm),
    .idle(ctl_q.idle), .act(ctl_q.act), .hit_a(hit_a), .cnt(count_o),
    .cmp_a(cmpa_q), .wave(wave_o), .wave_n(wave_n_o)
  );

  assign flag_p_o = flags[0];
  assign flag_a_o = flags[1];

endmodule

// File: rtl/mpt_checker.sv
`timescale 1ns/1ps
module mpt_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             idle,
  input logic             pwm,
  input logic             clr_on_a,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_p,
  input logic             clr_p,
  input logic             flag_p,
  input logic             wave,
  input logic             wave_n
);

  p_complement_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wave_n == !wave);

  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> wave == idle);

  p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_p && !clr_p) |=> flag_p);

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == cmp_p) |=> flag_p);

  p_clear_on_p_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pwm && !clr_on_a && cnt == cmp_p) |=> cnt == '0);

  p_pwm_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pwm && cnt == cmp_p) |=> cnt == '0);

endmodule

bind match_pwm_timer mpt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .run(ctl_q.run), .idle(ctl_q.idle),
  .pwm(ctl_q.pwm), .clr_on_a(ctl_q.clr_on_a), .tick(tick), .cnt(count_o),
  .cmp_p(cmpp_q), .clr_p(flag_clr[0]), .flag_p(flag_p_o),
  .wave(wave_o), .wave_n(wave_n_o)
);

// File: tb/match_pwm_timer_test.sv
`timescale 1ns/1ps
module match_pwm_timer_test;
  localparam int CNT_W = 10;
  localparam int MAXC  = 1 << CNT_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = 2'd0;
  logic [15:0]      wr_data = 16'd0;
  logic             hi_tick = 1'b0;
  logic             sub_tick = 1'b0;
  logic             ext_clk = 1'b0;
  logic             wave_o, wave_n_o, flag_p_o, flag_a_o;
  logic [CNT_W-1:0] count_o;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  int       m_cnt, cP, cA, rP, rA;
  bit       m_fp, m_fa, m_cmp, cpwm, cclrA, cidle;
  bit [1:0] cact;

  match_pwm_timer #(.CNT_W(CNT_W), .DATA_W(16), .NUM_RATIOS(4)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hi_tick(hi_tick), .sub_tick(sub_tick),
    .ext_clk(ext_clk), .wave_o(wave_o), .wave_n_o(wave_n_o),
    .flag_p_o(flag_p_o), .flag_a_o(flag_a_o), .count_o(count_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ctlw(bit run, bit [2:0] sel, bit pwm,
                                       bit [1:0] act, bit clra, bit fall, bit idle);
    return {6'b0, idle, fall, clra, act, pwm, sel, run};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  // reference model of one active tick (R4 R5 R6 R7 R10)
  task automatic step(input bit [1:0] clr);
    bit mp, ma, restart;
    mp = (m_cnt == rP);
    ma = (m_cnt == rA);
    restart = cpwm ? mp : (cclrA ? ma : mp);
    m_fp = (m_fp && !clr[0]) || mp;
    m_fa = (m_fa && !clr[1]) || ma;
    if (!cpwm && ma) begin
      case (cact)
        2'd1: m_cmp = 1'b0;
        2'd2: m_cmp = 1'b1;
        2'd3: m_cmp = !m_cmp;
        default: ;
      endcase
    end
    m_cnt = restart ? 0 : (m_cnt + 1) % MAXC;
  endtask

  function automatic int exp_wave();
    return cpwm ? int'(m_cnt < rA) : int'(m_cmp);
  endfunction

  task automatic check_all();
    chk("R5/R7/R10 count", int'(count_o), m_cnt);
    chk("R6/R7 wave", int'(wave_o), exp_wave());
    chk("R8 complement", int'(wave_n_o), 1 - exp_wave());
    chk("R4 flag P", int'(flag_p_o), int'(m_fp));
    chk("R4 flag A", int'(flag_a_o), int'(m_fa));
  endtask

  task automatic run_cfg(input int n, input int clr_at, input bit [1:0] clr_bits, input bit rel);
    int c;
    @(negedge clk);
    wr(2'd0, ctlw(1'b0, 3'd0, cpwm, cact, cclrA, 1'b0, cidle));
    @(negedge clk);
    c  = int'(count_o);
    rP = rel ? (c + cP) % MAXC : cP;
    rA = rel ? (c + cA) % MAXC : cA;
    wr(2'd1, 16'(rP));
    wr(2'd2, 16'(rA));
    wr(2'd3, 16'h0003);
    @(negedge clk);
    m_cnt = c; m_fp = 1'b0; m_fa = 1'b0; m_cmp = cidle;
    chk("R9 idle before run", int'(wave_o), int'(cidle));
    chk("R4 flags cleared", int'({flag_a_o, flag_p_o}), 0);
    wr(2'd0, ctlw(1'b1, 3'd0, cpwm, cact, cclrA, 1'b0, cidle));
    for (int i = 1; i <= n; i++) begin
      if (i == clr_at) begin
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = {14'b0, clr_bits};
      end
      @(posedge clk);
      step((i == clr_at) ? clr_bits : 2'b00);
      #1 wr_en = 1'b0;
      @(negedge clk);
      check_all();
    end
    wr_en = 1'b1; wr_addr = 2'd0;
    wr_data = ctlw(1'b0, 3'd0, cpwm, cact, cclrA, 1'b0, cidle);
    @(posedge clk);
    step(2'b00);
    #1 wr_en = 1'b0;
    @(negedge clk);
    chk("R9 idle after stop", int'(wave_o), int'(cidle));
    chk("R9 count at stop", int'(count_o), m_cnt);
    repeat (3) @(negedge clk);
    chk("R9 count held", int'(count_o), m_cnt);
    chk("R4 flag P sticky", int'(flag_p_o), int'(m_fp));
  endtask

  // counting-source check for the clock-select field (R2 R3)
  task automatic burst(input bit [2:0] sel, input bit fall);
    int c, expd;
    bit lvl;
    @(negedge clk);
    wr(2'd0, ctlw(1'b0, sel, 1'b0, 2'd0, 1'b0, fall, 1'b0));
    @(negedge clk);
    c = int'(count_o);
    wr(2'd1, 16'((c + 512) % MAXC));
    wr(2'd2, 16'((c + 512) % MAXC));
    lvl = ext_clk;
    repeat (4) @(negedge clk);
    wr(2'd0, ctlw(1'b1, sel, 1'b0, 2'd0, 1'b0, fall, 1'b0));
    expd = 0;
    for (int i = 1; i <= 64; i++) begin
      @(negedge clk);
      hi_tick  = 1'($urandom % 2);
      sub_tick = 1'($urandom % 2);
      if (i % 3 == 0 && i < 56) begin
        lvl = !lvl;
        ext_clk = lvl;
        if (sel == 3'd6 && (lvl != fall)) expd++;
      end
      if (sel == 3'd4 && hi_tick)  expd++;
      if (sel == 3'd5 && sub_tick) expd++;
      if (i == 64) begin
        wr_en = 1'b1; wr_addr = 2'd0;
        wr_data = ctlw(1'b0, sel, 1'b0, 2'd0, 1'b0, fall, 1'b0);
      end
      @(posedge clk);
      #1 hi_tick = 1'b0; sub_tick = 1'b0; wr_en = 1'b0;
    end
    if (sel < 3'd4) expd = 64 >> (2 * int'(sel));
    repeat (4) @(negedge clk);
    if (sel == 3'd6)      chk("R3 external edge count", int'(count_o), (c + expd) % MAXC);
    else if (sel < 3'd4)  chk("R2 ratio count", int'(count_o), (c + expd) % MAXC);
    else                  chk("R2 tick source count", int'(count_o), (c + expd) % MAXC);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset count", int'(count_o), 0);
    chk("R1 reset flags", int'({flag_a_o, flag_p_o}), 0);
    chk("R1 reset wave", int'(wave_o), 0);
    chk("R1 reset wave_n", int'(wave_n_o), 1);

    for (int s = 0; s < 8; s++) burst(3'(s), 1'b0);
    burst(3'd6, 1'b1);

    // R6: each match action in compare mode
    cpwm = 1'b0; cclrA = 1'b0; cP = 7; cA = 3;
    for (int a = 0; a < 4; a++) begin
      cact = 2'(a); cidle = a[0];
      run_cfg(30, 0, 2'b00, 1'b0);
    end

    // R7: PWM with mid duty, zero duty and duty above period
    cpwm = 1'b1; cclrA = 1'b1; cact = 2'd3; cidle = 1'b0; cP = 9;
    cA = 4;  run_cfg(40, 0, 2'b00, 1'b0);
    cA = 0;  run_cfg(25, 0, 2'b00, 1'b0);
    cA = 12; run_cfg(25, 0, 2'b00, 1'b0);

    // R5: A as clear source, P match only flags
    cpwm = 1'b0; cclrA = 1'b1; cact = 2'd3; cP = 2; cA = 12;
    run_cfg(40, 0, 2'b00, 1'b0);

    // R4: clear write on the same edge as a P match, then a plain clear
    cclrA = 1'b0; cact = 2'd0; cP = 3; cA = 500;
    run_cfg(8, 4, 2'b01, 1'b1);
    run_cfg(8, 6, 2'b11, 1'b1);

    // R10: count through the top value to 0 without a match
    @(negedge clk);
    if (count_o == '0) begin
      cP = 5; cA = 600;
      run_cfg(1, 0, 2'b00, 1'b1);
    end
    cP = MAXC - 1; cA = MAXC - 1;
    run_cfg(MAXC + 4, 0, 2'b00, 1'b1);

    for (int t = 0; t < 40; t++) begin
      cP    = 2 + int'($urandom % 60);
      cA    = int'($urandom % 32'(cP + 3));
      cpwm  = 1'($urandom % 2);
      cclrA = 1'($urandom % 2);
      cact  = 2'($urandom % 4);
      cidle = 1'($urandom % 2);
      run_cfg(20 + int'($urandom % 100), 1 + int'($urandom % 120),
              2'($urandom % 4), 1'b0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule